// File: doc/BRIEF.md
# Paged RAM Enable Controller

This block sits between a CPU-side bus and a fast on-chip RAM that is split into four pages of 256 bytes. A small 8-bit control register holds one enable bit per page. While a page is enabled, CPU reads and writes reach the RAM. While it is disabled, reads return the filler word `0xDEADBEEF` and writes are dropped. The RAM itself never sees a request for a disabled page.

Writes to an enabled page are posted. Each page keeps a one-entry buffer that holds the most recent write: its word address, data and byte strobes. The buffer is written into the RAM only when the next access to that same page is accepted. If software clears a page's enable bit while that page still has a write waiting, the write is lost. A read of a buffered word whose four strobes are all set is answered from the buffer, and no RAM read is issued. The block also models the ordering hazard that follows a register write: a RAM access issued as the very next request is refused and flagged.

Both edges of the block are valid/ready streams. A CPU request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` is high only while the block is idle, so it back-pressures the next request until the current response has been consumed. A response is held with stable contents until `cpu_rsp_ready` is high. On the RAM side, a request is held stable until `ram_req_ready` is high. Read data is returned by the RAM in the cycle after the read request is accepted.

Top module: `paged_ram_gate`

## Requirements
- R1: After reset all four page enable bits are 1, so a register read returns 0x0F.
- R2: The control register sits at byte address 0x400 and is reached only with `cpu_be` = 4'b0001, with its data on bits 7:0. Bit p (p = 0..3) enables page p, which covers byte addresses p*0x100 to p*0x100+0xFF. Bits 7:4 always read as 0.
- R3: A register access whose `cpu_be` is not 4'b0001, or any access to an address that is neither RAM (below 0x400) nor the register, is ignored. It answers with `cpu_rsp_err` = 1 and read data 0, and the register keeps its value.
- R4: A read of an enabled page returns the RAM word. A write to an enabled page issues no RAM write when it is accepted. Instead, the page's previous buffered write is committed to the RAM as the first step of the next accepted access to that page, before that access is served.
- R5: A read of a word that is buffered with all four strobes set returns the buffered data. It commits the buffer with one RAM write and issues no RAM read.
- R6: An access to a disabled page issues no RAM request. A read returns 0xDEADBEEF, and a write is dropped, so the word is unchanged once the page is enabled again.
- R7: A register write that clears a page's enable bit discards any write still buffered for that page, so that write never reaches the RAM.
- R8: The first request accepted after a valid register write, if it targets RAM, is refused. It answers with `cpu_rsp_hazard` = 1 and read data 0xDEADBEEF, makes no RAM request and changes no buffer. If that first request is a register read, it is served normally and RAM service resumes after it. A response never has both `cpu_rsp_hazard` and `cpu_rsp_err` set.
- R9: `cpu_req_ready` is low from acceptance until the response is consumed. `cpu_rsp_valid` and `cpu_rsp_rdata` stay stable while `cpu_rsp_ready` is low.
- R10: A RAM request keeps `ram_req_valid`, `ram_we`, `ram_addr` and `ram_wdata` stable until `ram_req_ready` is high. Read data is taken from `ram_rdata` in the cycle after the read is accepted, and results are correct when the RAM stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block can accept a request (idle) |
| cpu_addr | input | 11 | Byte address of the access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte enables; 4'b0001 marks a byte access to lane 0 |
| cpu_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | CPU takes the response |
| cpu_rsp_rdata | output | 32 | Read data (0 for writes) |
| cpu_rsp_err | output | 1 | Access was ignored as malformed or unmapped |
| cpu_rsp_hazard | output | 1 | RAM access refused because it directly followed a register write |
| ram_req_valid | output | 1 | RAM request valid |
| ram_req_ready | input | 1 | RAM accepts the request |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | 8 | RAM word address; bits 7:6 are the page |
| ram_wdata | output | 32 | RAM write data |
| ram_wstrb | output | 4 | RAM byte write strobes |
| ram_rdata | input | 32 | RAM read data, valid the cycle after an accepted read |

## Verification
The bound checker watches the protocol rules on every cycle. It checks that RAM and CPU requests and responses are held stable under back-pressure, and that the block never accepts a request while a response is pending. It also checks that no RAM request ever addresses a disabled page, that no buffer stays valid for a disabled page, and that hazard responses carry the filler word and never the error flag. The deferred commit of posted writes depends on the order of several accesses, and so does the loss of a write when a page is disabled. The bench's scenarios show these, along with forwarding without a RAM read, the data that comes back after re-enabling, and the recovery after the hazard. The bench counts RAM transactions in its own memory model to tell whether each one happened.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMMIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RSP
  } pg_state_t;

  typedef struct packed {
    logic is_reg;
    logic is_ram;
    logic byte_ok;
  } pg_kind_t;

endpackage

// File: rtl/pg_decode.sv
module pg_decode #(
  parameter int ADDR_W     = 11,
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 256,
  parameter int BE_W       = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 11'h400
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [BE_W-1:0]                 be,
  output pg_pkg::pg_kind_t                kind,
  output logic [$clog2(NUM_PAGES)-1:0]    page,
  output logic [$clog2(NUM_PAGES*PAGE_BYTES/BE_W)-1:0] word
);
  localparam int PAGE_W   = $clog2(NUM_PAGES);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int LANE_W   = $clog2(BE_W);
  localparam int RAM_BA_W = OFF_W + PAGE_W;
  localparam int WORD_W   = RAM_BA_W - LANE_W;

  logic lane0_only;
  assign lane0_only = (be == BE_W'(1));

  always_comb begin
    kind.is_ram  = (addr[ADDR_W-1:RAM_BA_W] == '0);
    kind.is_reg  = (addr[ADDR_W-1:LANE_W] == REG_ADDR[ADDR_W-1:LANE_W]);
    kind.byte_ok = lane0_only;
  end

  assign page = addr[OFF_W +: PAGE_W];
  assign word = addr[LANE_W +: WORD_W];
endmodule

// File: rtl/pg_ctrl_reg.sv
module pg_ctrl_reg #(
  parameter int NUM_PAGES = 4,
  parameter int REG_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 accept,
  output logic [NUM_PAGES-1:0] page_en,
  output logic [NUM_PAGES-1:0] drop_mask,
  output logic                 hazard_win,
  output logic [REG_W-1:0]     rd_value
);
  localparam int PAD_W = REG_W - NUM_PAGES;

  logic [NUM_PAGES-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '1;
      hazard_win <= 1'b0;
    end else begin
      if (wr) en_q <= wr_data[NUM_PAGES-1:0];
      if (wr)          hazard_win <= 1'b1;
      else if (accept) hazard_win <= 1'b0;
    end
  end

  assign page_en   = en_q;
  assign drop_mask = wr ? (en_q & ~wr_data[NUM_PAGES-1:0]) : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_value = {{PAD_W{1'b0}}, en_q};
    end else begin : g_nopad
      assign rd_value = en_q;
    end
  endgenerate
endmodule

// File: rtl/pg_wbuf.sv
module pg_wbuf #(
  parameter int WORD_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_W-1:0]   ld_addr,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic [DATA_W/8-1:0] ld_strb,
  input  logic                clear,
  output logic                vld,
  output logic [WORD_W-1:0]   addr,
  output logic [DATA_W-1:0]   data,
  output logic [DATA_W/8-1:0] strb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      addr <= '0;
      data <= '0;
      strb <= '0;
    end else if (load) begin
      vld  <= 1'b1;
      addr <= ld_addr;
      data <= ld_data;
      strb <= ld_strb;
    end else if (clear) begin
      vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/paged_ram_gate.sv
module paged_ram_gate #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 32,
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 256,
  parameter int REG_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 11'h400,
  parameter logic [DATA_W-1:0] FILL     = 32'hDEADBEEF,
  localparam int BE_W   = DATA_W / 8,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int RAM_AW = $clog2(NUM_PAGES * PAGE_BYTES / BE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_err,
  output logic              cpu_rsp_hazard,
  output logic              ram_req_valid,
  input  logic              ram_req_ready,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [BE_W-1:0]   ram_wstrb,
  input  logic [DATA_W-1:0] ram_rdata
);
  import pg_pkg::*;

  pg_state_t state;

  // request decode
  pg_kind_t          d_kind;
  logic [PAGE_W-1:0] d_page;
  logic [RAM_AW-1:0] d_word;

  pg_decode #(
    .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
    .BE_W(BE_W), .REG_ADDR(REG_ADDR)
  ) u_decode (
    .addr(cpu_addr), .be(cpu_be), .kind(d_kind), .page(d_page), .word(d_word)
  );

  logic acc;
  assign cpu_req_ready = (state == ST_IDLE);
  assign acc           = cpu_req_valid && cpu_req_ready;

  // control register
  logic                 reg_wr;
  logic [NUM_PAGES-1:0] page_en;
  logic [NUM_PAGES-1:0] drop_mask;
  logic                 hazard_win;
  logic [REG_W-1:0]     reg_value;

  assign reg_wr = acc && d_kind.is_reg && d_kind.byte_ok && cpu_we;

  pg_ctrl_reg #(.NUM_PAGES(NUM_PAGES), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wr_data(cpu_wdata[REG_W-1:0]),
    .accept(acc), .page_en(page_en), .drop_mask(drop_mask),
    .hazard_win(hazard_win), .rd_value(reg_value)
  );

  // latched request
  logic              q_we;
  logic [BE_W-1:0]   q_be;
  logic [DATA_W-1:0] q_wdata;
  logic [PAGE_W-1:0] q_page;
  logic [RAM_AW-1:0] q_word;
  logic              q_fwd;

  // per-page posted write buffers
  logic [NUM_PAGES-1:0] buf_vld;
  logic [RAM_AW-1:0]    buf_addr [NUM_PAGES];
  logic [DATA_W-1:0]    buf_data [NUM_PAGES];
  logic [BE_W-1:0]      buf_strb [NUM_PAGES];

  logic              ld_fire;
  logic [PAGE_W-1:0] ld_page;
  logic [RAM_AW-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic [BE_W-1:0]   ld_strb;
  logic              commit_done;
  logic              ram_ok;
  logic              hit_full;

  assign commit_done = (state == ST_COMMIT) && ram_req_ready;
  assign ram_ok      = acc && d_kind.is_ram && !d_kind.is_reg && !hazard_win
                       && page_en[d_page];
  assign hit_full    = (buf_addr[d_page] == d_word) && (buf_strb[d_page] == '1);

  always_comb begin
    if (state == ST_IDLE) begin
      ld_fire = ram_ok && cpu_we && !buf_vld[d_page];
      ld_page = d_page;
      ld_addr = d_word;
      ld_data = cpu_wdata;
      ld_strb = cpu_be;
    end else begin
      ld_fire = commit_done && q_we;
      ld_page = q_page;
      ld_addr = q_word;
      ld_data = q_wdata;
      ld_strb = q_be;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      logic pg_load;
      logic pg_clear;
      assign pg_load  = ld_fire && (ld_page == PAGE_W'(p));
      assign pg_clear = drop_mask[p] ||
                        (commit_done && !q_we && (q_page == PAGE_W'(p)));
      pg_wbuf #(.WORD_W(RAM_AW), .DATA_W(DATA_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .load(pg_load), .ld_addr(ld_addr), .ld_data(ld_data), .ld_strb(ld_strb),
        .clear(pg_clear),
        .vld(buf_vld[p]), .addr(buf_addr[p]), .data(buf_data[p]), .strb(buf_strb[p])
      );
    end
  endgenerate

  // sequencer
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_err;
  logic              rsp_hz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_we     <= 1'b0;
      q_be     <= '0;
      q_wdata  <= '0;
      q_page   <= '0;
      q_word   <= '0;
      q_fwd    <= 1'b0;
      rsp_data <= '0;
      rsp_err  <= 1'b0;
      rsp_hz   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (acc) begin
          q_we     <= cpu_we;
          q_be     <= cpu_be;
          q_wdata  <= cpu_wdata;
          q_page   <= d_page;
          q_word   <= d_word;
          q_fwd    <= 1'b0;
          rsp_data <= '0;
          rsp_err  <= 1'b0;
          rsp_hz   <= 1'b0;
          if (d_kind.is_reg) begin
            rsp_err <= !d_kind.byte_ok;
            if (d_kind.byte_ok && !cpu_we) rsp_data <= DATA_W'(reg_value);
            state <= ST_RSP;
          end else if (!d_kind.is_ram) begin
            rsp_err <= 1'b1;
            state   <= ST_RSP;
          end else if (hazard_win) begin
            rsp_hz   <= 1'b1;
            rsp_data <= FILL;
            state    <= ST_RSP;
          end else if (!page_en[d_page]) begin
            if (!cpu_we) rsp_data <= FILL;
            state <= ST_RSP;
          end else if (buf_vld[d_page]) begin
            q_fwd <= !cpu_we && hit_full;
            if (!cpu_we && hit_full) rsp_data <= buf_data[d_page];
            state <= ST_COMMIT;
          end else if (cpu_we) begin
            state <= ST_RSP;
          end else begin
            state <= ST_RD_REQ;
          end
        end
        ST_COMMIT: if (ram_req_ready) begin
          state <= (q_we || q_fwd) ? ST_RSP : ST_RD_REQ;
        end
        ST_RD_REQ: if (ram_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          rsp_data <= ram_rdata;
          state    <= ST_RSP;
        end
        ST_RSP: if (cpu_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rsp_valid  = (state == ST_RSP);
  assign cpu_rsp_rdata  = rsp_data;
  assign cpu_rsp_err    = rsp_err;
  assign cpu_rsp_hazard = rsp_hz;

  // RAM request port
  always_comb begin
    ram_req_valid = (state == ST_COMMIT) || (state == ST_RD_REQ);
    ram_we        = (state == ST_COMMIT);
    if (state == ST_COMMIT) begin
      ram_addr  = buf_addr[q_page];
      ram_wdata = buf_data[q_page];
      ram_wstrb = buf_strb[q_page];
    end else begin
      ram_addr  = q_word;
      ram_wdata = '0;
      ram_wstrb = '0;
    end
  end
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int DATA_W    = 32,
  parameter int NUM_PAGES = 4,
  parameter int RAM_AW    = 8,
  parameter logic [DATA_W-1:0] FILL = 32'hDEADBEEF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_req_ready,
  input logic                 cpu_rsp_valid,
  input logic                 cpu_rsp_ready,
  input logic [DATA_W-1:0]    cpu_rsp_rdata,
  input logic                 cpu_rsp_err,
  input logic                 cpu_rsp_hazard,
  input logic                 ram_req_valid,
  input logic                 ram_req_ready,
  input logic                 ram_we,
  input logic [RAM_AW-1:0]    ram_addr,
  input logic [DATA_W-1:0]    ram_wdata,
  input logic [NUM_PAGES-1:0] page_en,
  input logic [NUM_PAGES-1:0] buf_vld
);
  localparam int PAGE_W = $clog2(NUM_PAGES);

  assert_ram_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_valid && !ram_req_ready |=> ram_req_valid && $stable(ram_we)
      && $stable(ram_addr) && $stable(ram_wdata));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)
      && $stable(cpu_rsp_err) && $stable(cpu_rsp_hazard));

  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

  assert_no_disabled_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_valid |-> page_en[ram_addr[RAM_AW-1 -: PAGE_W]]);

  assert_drop_on_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_vld & ~page_en) == '0);

  assert_hazard_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && cpu_rsp_hazard |-> cpu_rsp_rdata == FILL && !cpu_rsp_err);
endmodule

bind paged_ram_gate pg_checker #(
  .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .RAM_AW(RAM_AW), .FILL(FILL)
) i_pg_checker (
  .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
  .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_err(cpu_rsp_err),
  .cpu_rsp_hazard(cpu_rsp_hazard), .ram_req_valid(ram_req_valid),
  .ram_req_ready(ram_req_ready), .ram_we(ram_we), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .page_en(page_en), .buf_vld(buf_vld)
);

// File: tb/test_paged_ram_gate.sv
module test_paged_ram_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [10:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b1;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_err;
  logic        cpu_rsp_hazard;
  logic        ram_req_valid;
  logic        ram_req_ready;
  logic        ram_we;
  logic [7:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic [3:0]  ram_wstrb;
  logic [31:0] ram_rdata;

  always #5 clk = ~clk;

  paged_ram_gate i_paged_ram_gate (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_err(cpu_rsp_err),
    .cpu_rsp_hazard(cpu_rsp_hazard),
    .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_wstrb(ram_wstrb), .ram_rdata(ram_rdata)
  );

  // RAM model
  logic [31:0] mem [256];
  logic        stall = 1'b0;
  logic        tog = 1'b0;
  int          ram_wr_cnt = 0;
  int          ram_rd_cnt = 0;

  function automatic logic [31:0] init_word(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, b, 8'hC3, ~b};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_word(i);
  end

  assign ram_req_ready = stall ? tog : 1'b1;

  always @(posedge clk) begin
    tog <= ~tog;
    if (ram_req_valid && ram_req_ready) begin
      if (ram_we) begin
        ram_wr_cnt <= ram_wr_cnt + 1;
        for (int k = 0; k < 4; k++)
          if (ram_wstrb[k]) mem[ram_addr][k*8 +: 8] <= ram_wdata[k*8 +: 8];
      end else begin
        ram_rd_cnt <= ram_rd_cnt + 1;
        ram_rdata  <= mem[ram_addr];
      end
    end
  end

  int n_checks = 0;
  int n_fail   = 0;
  int hold_n   = 0;
  int hold_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic cpu_do(input logic [10:0] a, input logic w, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic er, output logic hz);
    @(negedge clk);
    cpu_rsp_ready = (hold_n == 0);
    cpu_req_valid = 1'b1;
    cpu_addr = a; cpu_we = w; cpu_be = be; cpu_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_rdata; er = cpu_rsp_err; hz = cpu_rsp_hazard;
    hold_bad = 0;
    for (int i = 0; i < hold_n; i++) begin
      @(negedge clk);
      if (!cpu_rsp_valid || cpu_rsp_rdata !== rd || cpu_req_ready) hold_bad++;
    end
    cpu_rsp_ready = 1'b1;
    @(posedge clk);
  endtask

  logic [31:0] rd;
  logic        er, hz;
  int          w0, r0;

  task automatic t_reset();
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    check("R1 reset enables", rd, 32'h0F);
    check("R1 reset err", {31'b0, er}, 0);
  endtask

  task automatic t_reg_rw();
    cpu_do(11'h400, 1, 4'b0001, 32'hFF, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    check("R2 upper bits zero", rd, 32'h0F);
    cpu_do(11'h400, 1, 4'b0001, 32'h05, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    check("R2 write readback", rd, 32'h05);
    cpu_do(11'h400, 1, 4'b0001, 32'h0F, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
  endtask

  task automatic t_size_err();
    cpu_do(11'h400, 1, 4'b1111, 32'h0, rd, er, hz);
    check("R3 word reg write err", {31'b0, er}, 1);
    cpu_do(11'h400, 0, 4'b0011, 0, rd, er, hz);
    check("R3 half reg read err", {31'b0, er}, 1);
    check("R3 half reg read data", rd, 0);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    check("R3 reg unchanged", rd, 32'h0F);
    cpu_do(11'h520, 0, 4'b1111, 0, rd, er, hz);
    check("R3 unmapped err", {31'b0, er}, 1);
  endtask

  task automatic t_read_enabled();
    r0 = ram_rd_cnt;
    cpu_do(11'h00C, 0, 4'b1111, 0, rd, er, hz);
    check("R4 enabled read data", rd, init_word(3));
    check("R4 one RAM read", ram_rd_cnt - r0, 1);
  endtask

  task automatic t_posted();
    w0 = ram_wr_cnt;
    cpu_do(11'h104, 1, 4'b1111, 32'hCAFE0001, rd, er, hz);
    check("R4 write is posted", ram_wr_cnt - w0, 0);
    cpu_do(11'h108, 0, 4'b1111, 0, rd, er, hz);
    check("R4 other word read", rd, init_word(8'h42));
    check("R4 commit on next access", ram_wr_cnt - w0, 1);
    check("R4 RAM holds write", mem[8'h41], 32'hCAFE0001);
    cpu_do(11'h104, 0, 4'b1111, 0, rd, er, hz);
    check("R4 read back committed", rd, 32'hCAFE0001);
  endtask

  task automatic t_forward();
    w0 = ram_wr_cnt; r0 = ram_rd_cnt;
    cpu_do(11'h200, 1, 4'b1111, 32'h12345678, rd, er, hz);
    cpu_do(11'h200, 0, 4'b1111, 0, rd, er, hz);
    check("R5 forwarded data", rd, 32'h12345678);
    check("R5 no RAM read", ram_rd_cnt - r0, 0);
    check("R5 one commit", ram_wr_cnt - w0, 1);
    cpu_do(11'h204, 1, 4'b0001, 32'h000000AB, rd, er, hz);
    cpu_do(11'h204, 0, 4'b1111, 0, rd, er, hz);
    check("R4 partial merge", rd, {init_word(8'h81)[31:8], 8'hAB});
  endtask

  task automatic t_disable();
    cpu_do(11'h400, 1, 4'b0001, 32'h0E, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    w0 = ram_wr_cnt; r0 = ram_rd_cnt;
    cpu_do(11'h010, 0, 4'b1111, 0, rd, er, hz);
    check("R6 disabled read filler", rd, 32'hDEADBEEF);
    cpu_do(11'h010, 1, 4'b1111, 32'h0BADF00D, rd, er, hz);
    cpu_do(11'h014, 0, 4'b1111, 0, rd, er, hz);
    check("R6 no RAM traffic", (ram_wr_cnt - w0) + (ram_rd_cnt - r0), 0);
    cpu_do(11'h400, 1, 4'b0001, 32'h0F, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    cpu_do(11'h010, 0, 4'b1111, 0, rd, er, hz);
    check("R6 write was dropped", rd, init_word(4));
  endtask

  task automatic t_lost();
    w0 = ram_wr_cnt;
    cpu_do(11'h300, 1, 4'b1111, 32'h55AA55AA, rd, er, hz);
    cpu_do(11'h400, 1, 4'b0001, 32'h07, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    cpu_do(11'h400, 1, 4'b0001, 32'h0F, rd, er, hz);
    cpu_do(11'h400, 0, 4'b0001, 0, rd, er, hz);
    cpu_do(11'h300, 0, 4'b1111, 0, rd, er, hz);
    check("R7 pending write lost", rd, init_word(8'hC0));
    check("R7 never committed", ram_wr_cnt - w0, 0);
  endtask

  task automatic t_hazard();
    cpu_do(11'h400, 1, 4'b0001, 32'h0F, rd, er, hz);
    w0 = ram_wr_cnt; r0 = ram_rd_cnt;
    cpu_do(11'h018, 0, 4'b1111, 0, rd, er, hz);
    check("R8 hazard flag", {31'b0, hz}, 1);
    check("R8 hazard filler", rd, 32'hDEADBEEF);
    check("R8 hazard no RAM", (ram_wr_cnt - w0) + (ram_rd_cnt - r0), 0);
    cpu_do(11'h018, 0, 4'b1111, 0, rd, er, hz);
    check("R8 resumes", rd, init_word(6));
    check("R8 flag cleared", {31'b0, hz}, 0);
    cpu_do(11'h400, 1, 4'b0001, 32'h0F, rd, er, hz);
    cpu_do(11'h01C, 1, 4'b1111, 32'hFEEDFACE, rd, er, hz);
    check("R8 hazard on write", {31'b0, hz}, 1);
    cpu_do(11'h01C, 0, 4'b1111, 0, rd, er, hz);
    check("R8 hazard write dropped", rd, init_word(7));
  endtask

  task automatic t_stall();
    stall = 1'b1;
    cpu_do(11'h110, 1, 4'b1100, 32'hBEEF0000, rd, er, hz);
    cpu_do(11'h110, 0, 4'b1111, 0, rd, er, hz);
    check("R10 stalled merge", rd, {16'hBEEF, init_word(8'h44)[15:0]});
    hold_n = 4;
    cpu_do(11'h0A0, 0, 4'b1111, 0, rd, er, hz);
    hold_n = 0;
    check("R9 response held", hold_bad, 0);
    check("R10 stalled read", rd, init_word(8'h28));
    stall = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg_rw();
    t_size_err();
    t_read_enabled();
    t_posted();
    t_forward();
    t_disable();
    t_lost();
    t_hazard();
    t_stall();
    repeat (4) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule